// File: doc/BRIEF.md
# Two-Level Segment/Page Address Translator

This block turns a 24-bit virtual address into a physical address in two steps. The top four bits pick one of sixteen segment descriptors, which are held as a flat input vector supplied by the surrounding logic. Each descriptor carries a page-table base address, a limit given as a page count, and access rights. The walker checks the access against the rights and then checks the page number against the limit. Only if both checks pass does it fetch a 2-byte page-table entry from memory. The entry's value is the frame number, and the result is that frame number followed by the 12-bit page offset.

Requests arrive on a valid/ready port, and the walker handles one translation at a time. The page-table read goes out on a one-cycle request strobe with an address. The data comes back on a valid strobe some number of cycles later. The outcome is given as a one-cycle result pulse that carries either a physical address or a fault code.

Top module: `segpage_walker`

## Requirements
- R1: A translation that does not fault gives `rsp_paddr = {pte, offset}`. Here `pte` is the 16-bit word returned on `mem_data`, and `offset` is `req_vaddr[11:0]`.
- R2: The segment is `req_vaddr[23:20]` and the page is `req_vaddr[19:12]`. Exactly one page-table read is issued, at `mem_addr = base + 2*page` modulo 2^24.
- R3: If the page number is greater than or equal to the segment's limit, the result is fault code 2'b01 (limit), and no memory read is issued. A limit of 256 allows every page.
- R4: Rights bit 0 means readable and bit 1 means writable. If bit 0 is clear, every access gets fault code 2'b10 (rights). If bit 1 is clear, a write gets fault code 2'b10. In both cases no memory read is issued.
- R5: When both a rights fault and a limit fault apply, the rights fault (2'b10) is reported.
- R6: `req_ready` is high only while the walker is idle. A request presented while it is busy has no effect on the translation in progress or on its result.
- R7: `rsp_valid` is high for exactly one cycle per translation. On a fault, `rsp_paddr` is zero. Fault code 2'b11 never appears. In the cycle after the result, `req_ready` is high again.
- R8: `mem_req` is a single-cycle strobe. The walker waits any number of cycles for `mem_valid` and ignores `mem_valid` in the cycle the strobe is raised.
- R9: After reset, `req_ready` is high and `mem_req` and `rsp_valid` are low.
- R10: Descriptor s sits at bits `[s*35 +: 35]` of `seg_table`, packed as {base[23:0], limit[8:0], rights[1:0]}, and only the descriptor named by the segment field is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_table | input | 560 | Sixteen packed segment descriptors |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 24 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_req | output | 1 | Page-table read strobe |
| mem_addr | output | 24 | Page-table entry byte address |
| mem_valid | input | 1 | Read data returned |
| mem_data | input | 16 | Page-table entry value |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 28 | Physical address, zero on fault |
| rsp_fault | output | 2 | 00 none, 01 limit, 10 rights |

## Verification
Fixed vectors cover the key cases:
- a read through segment 0 that must produce 0x01f424;
- a page past segment 2's limit;
- a segment with no rights;
- a write to a read-only segment whose page is also past its limit, which separates the priority order from the plain limit check;
- pages exactly at and one below the limit, and a full 256-page segment, which expose off-by-one compares.

Random addresses, access types and memory latencies of one to five cycles then run across segments with random descriptors, so that the entry-address arithmetic, the wait for data and the selection of the descriptor all get exercised. A random share of the requests keeps `req_valid` high with a different address while the walker is busy. A walker that wrongly takes that second request would report the wrong address.

// File: rtl/sptw_pkg.sv
package sptw_pkg;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_CHECK    = 3'd1,
        S_READ_PTE = 3'd2,
        S_WAIT_PTE = 3'd3,
        S_DONE     = 3'd4
    } walk_state_e;

    typedef enum logic [1:0] {
        F_NONE   = 2'b00,
        F_LIMIT  = 2'b01,
        F_RIGHTS = 2'b10
    } fault_e;

    localparam int RIGHTS_W = 2;
    localparam int RD_BIT   = 0;
    localparam int WR_BIT   = 1;

endpackage

// File: rtl/sptw_seg_select.sv
module sptw_seg_select #(
    parameter int SEG_W  = 4,
    parameter int PTB_W  = 24,
    parameter int BND_W  = 9,
    parameter int RGT_W  = 2,
    localparam int NSEG  = 1 << SEG_W,
    localparam int ENT_W = PTB_W + BND_W + RGT_W
) (
    input  logic [NSEG*ENT_W-1:0] table_flat,
    input  logic [SEG_W-1:0]      seg,
    output logic [PTB_W-1:0]      base,
    output logic [BND_W-1:0]      limit,
    output logic [RGT_W-1:0]      rights
);
    logic [ENT_W-1:0] entries [NSEG];

    for (genvar s = 0; s < NSEG; s++) begin : g_unpack
        assign entries[s] = table_flat[s*ENT_W +: ENT_W];
    end

    logic [ENT_W-1:0] sel;
    always_comb begin
        sel    = entries[seg];
        rights = sel[RGT_W-1:0];
        limit  = sel[RGT_W +: BND_W];
        base   = sel[RGT_W+BND_W +: PTB_W];
    end
endmodule

// File: rtl/sptw_access_check.sv
module sptw_access_check
    import sptw_pkg::*;
#(
    parameter int PAGE_W = 8,
    localparam int BND_W = PAGE_W + 1
) (
    input  logic [RIGHTS_W-1:0] rights,
    input  logic [BND_W-1:0]    limit,
    input  logic [PAGE_W-1:0]   page,
    input  logic                is_write,
    output fault_e              fault
);
    logic rights_bad;
    logic limit_bad;

    always_comb begin
        rights_bad = !rights[RD_BIT] || (is_write && !rights[WR_BIT]);
        limit_bad  = {1'b0, page} >= limit;
        if (rights_bad)      fault = F_RIGHTS;
        else if (limit_bad)  fault = F_LIMIT;
        else                 fault = F_NONE;
    end
endmodule

// File: rtl/sptw_addr_compose.sv
module sptw_addr_compose #(
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 12,
    parameter int PTB_W  = 24,
    parameter int PTE_W  = 16,
    localparam int PTE_SHIFT = $clog2(PTE_W / 8),
    localparam int PA_W  = PTE_W + OFF_W
) (
    input  logic [PTB_W-1:0]  base,
    input  logic [PAGE_W-1:0] page,
    input  logic [OFF_W-1:0]  offset,
    input  logic [PTE_W-1:0]  pte,
    output logic [PTB_W-1:0]  pte_addr,
    output logic [PA_W-1:0]   paddr
);
    always_comb begin
        pte_addr = base + (PTB_W'(page) << PTE_SHIFT);
        paddr    = {pte, offset};
    end
endmodule

// File: rtl/segpage_walker.sv
module segpage_walker
    import sptw_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 12,
    parameter int PTB_W  = 24,
    parameter int PTE_W  = 16,
    localparam int NSEG  = 1 << SEG_W,
    localparam int BND_W = PAGE_W + 1,
    localparam int ENT_W = PTB_W + BND_W + RIGHTS_W,
    localparam int VA_W  = SEG_W + PAGE_W + OFF_W,
    localparam int PA_W  = PTE_W + OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSEG*ENT_W-1:0] seg_table,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic                  req_write,
    output logic                  mem_req,
    output logic [PTB_W-1:0]      mem_addr,
    input  logic                  mem_valid,
    input  logic [PTE_W-1:0]      mem_data,
    output logic                  rsp_valid,
    output logic [PA_W-1:0]       rsp_paddr,
    output logic [1:0]            rsp_fault
);
    typedef struct packed {
        walk_state_e      state;
        logic [VA_W-1:0]  vaddr;
        logic             write;
        logic [PTB_W-1:0] pte_addr;
        logic [PA_W-1:0]  paddr;
        fault_e           fault;
    } walk_t;

    walk_t walk_d, walk_q;

    // field split of the held virtual address
    logic [SEG_W-1:0]  seg_f;
    logic [PAGE_W-1:0] page_f;
    logic [OFF_W-1:0]  off_f;
    assign seg_f  = walk_q.vaddr[OFF_W+PAGE_W +: SEG_W];
    assign page_f = walk_q.vaddr[OFF_W +: PAGE_W];
    assign off_f  = walk_q.vaddr[OFF_W-1:0];

    logic [PTB_W-1:0]    seg_base;
    logic [BND_W-1:0]    seg_limit;
    logic [RIGHTS_W-1:0] seg_rights;
    fault_e              chk_fault;
    logic [PTB_W-1:0]    pte_addr_w;
    logic [PA_W-1:0]     paddr_w;

    sptw_seg_select #(
        .SEG_W (SEG_W),
        .PTB_W (PTB_W),
        .BND_W (BND_W),
        .RGT_W (RIGHTS_W)
    ) u_sel (
        .table_flat (seg_table),
        .seg        (seg_f),
        .base       (seg_base),
        .limit      (seg_limit),
        .rights     (seg_rights)
    );

    sptw_access_check #(
        .PAGE_W (PAGE_W)
    ) u_chk_acc (
        .rights   (seg_rights),
        .limit    (seg_limit),
        .page     (page_f),
        .is_write (walk_q.write),
        .fault    (chk_fault)
    );

    sptw_addr_compose #(
        .PAGE_W (PAGE_W),
        .OFF_W  (OFF_W),
        .PTB_W  (PTB_W),
        .PTE_W  (PTE_W)
    ) u_addr (
        .base     (seg_base),
        .page     (page_f),
        .offset   (off_f),
        .pte      (mem_data),
        .pte_addr (pte_addr_w),
        .paddr    (paddr_w)
    );

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.state)
            S_IDLE: begin
                if (req_valid) begin
                    walk_d.state = S_CHECK;
                    walk_d.vaddr = req_vaddr;
                    walk_d.write = req_write;
                end
            end
            S_CHECK: begin
                walk_d.pte_addr = pte_addr_w;
                walk_d.fault    = chk_fault;
                walk_d.paddr    = '0;
                if (chk_fault != F_NONE) walk_d.state = S_DONE;
                else                     walk_d.state = S_READ_PTE;
            end
            S_READ_PTE: begin
                walk_d.state = S_WAIT_PTE;
            end
            S_WAIT_PTE: begin
                if (mem_valid) begin
                    walk_d.paddr = paddr_w;
                    walk_d.state = S_DONE;
                end
            end
            S_DONE: begin
                walk_d.state = S_IDLE;
            end
            default: walk_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q.state    <= S_IDLE;
            walk_q.vaddr    <= '0;
            walk_q.write    <= 1'b0;
            walk_q.pte_addr <= '0;
            walk_q.paddr    <= '0;
            walk_q.fault    <= F_NONE;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign req_ready = (walk_q.state == S_IDLE);
    assign mem_req   = (walk_q.state == S_READ_PTE);
    assign mem_addr  = walk_q.pte_addr;
    assign rsp_valid = (walk_q.state == S_DONE);
    assign rsp_paddr = walk_q.paddr;
    assign rsp_fault = walk_q.fault;

endmodule

// File: rtl/segpage_walker_chk.sv
module segpage_walker_chk #(
    parameter int PA_W = 28
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            mem_req,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [1:0]      rsp_fault
);
    // tracks whether a page-table read went out since the last accept
    logic rd_seen;
    always_ff @(posedge clk) begin
        if (!rst_n)                      rd_seen <= 1'b0;
        else if (req_valid && req_ready) rd_seen <= 1'b0;
        else if (mem_req)                rd_seen <= 1'b1;
    end

    a_r3_r4_fault_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'b00) |-> !rd_seen);

    a_r2_success_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'b00) |-> rd_seen);

    a_r7_fault_zero_paddr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0));

    a_r7_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault != 2'b11));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r6_no_read_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);
endmodule

bind segpage_walker segpage_walker_chk #(.PA_W(PA_W)) u_walk_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_req   (mem_req),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault)
);

// File: tb/segpage_walker_test.sv
`timescale 1ns/1ps
module segpage_walker_test;
    localparam int NSEG = 16;
    localparam int ENT_W = 35;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSEG*ENT_W-1:0] seg_table = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [23:0]       req_vaddr = '0;
    logic              req_write = 1'b0;
    logic              mem_req;
    logic [23:0]       mem_addr;
    logic              mem_valid = 1'b0;
    logic [15:0]       mem_data = '0;
    logic              rsp_valid;
    logic [27:0]       rsp_paddr;
    logic [1:0]        rsp_fault;

    int checks = 0;
    int errors = 0;

    logic [23:0] tb_base   [NSEG];
    logic [8:0]  tb_limit  [NSEG];
    logic [1:0]  tb_rights [NSEG];

    always #10 clk = ~clk;

    segpage_walker uut (
        .clk (clk), .rst_n (rst_n), .seg_table (seg_table),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_vaddr (req_vaddr), .req_write (req_write),
        .mem_req (mem_req), .mem_addr (mem_addr),
        .mem_valid (mem_valid), .mem_data (mem_data),
        .rsp_valid (rsp_valid), .rsp_paddr (rsp_paddr), .rsp_fault (rsp_fault)
    );

    function automatic logic [15:0] pte_of(input logic [23:0] a);
        logic [15:0] h;
        if (a == 24'h002022) return 16'h001f;
        h = (a[15:0] * 16'h9e37) ^ {8'h5a, a[23:16]};
        return h;
    endfunction

    function automatic logic [1:0] exp_fault(input logic [23:0] va, input bit wr);
        logic [3:0] s;
        s = va[23:20];
        if (!tb_rights[s][0] || (wr && !tb_rights[s][1])) return 2'b10;
        if ({1'b0, va[19:12]} >= tb_limit[s]) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [23:0] exp_pte_addr(input logic [23:0] va);
        return tb_base[va[23:20]] + {15'd0, va[19:12], 1'b0};
    endfunction

    task automatic pack_table();
        for (int s = 0; s < NSEG; s++)
            seg_table[s*ENT_W +: ENT_W] = {tb_base[s], tb_limit[s], tb_rights[s]};
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic xlat(input logic [23:0] va, input bit wr, input int lat, input bit poke);
        logic [1:0]  ef;
        logic [23:0] ea;
        logic [27:0] ep;
        logic [1:0]  gf;
        logic [27:0] gp;
        logic [23:0] ma;
        int reads;
        bit got;
        ef = exp_fault(va, wr);
        ea = exp_pte_addr(va);
        ep = (ef == 2'b00) ? {pte_of(ea), va[11:0]} : 28'd0;
        reads = 0; got = 1'b0; gf = '0; gp = '0; ma = '0;
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        if (poke) begin
            req_vaddr = ~va; req_write = ~wr;    // R6: ignored while busy
        end else begin
            req_valid = 1'b0;
        end
        for (int i = 0; i < 60 && !got; i++) begin
            if (rsp_valid) begin
                got = 1'b1; gf = rsp_fault; gp = rsp_paddr; req_valid = 1'b0;
            end else if (mem_req) begin
                reads++; ma = mem_addr;
                repeat (lat) @(negedge clk);
                mem_data = pte_of(ma); mem_valid = 1'b1;
                @(negedge clk);
                mem_valid = 1'b0; mem_data = 16'hdead;
            end else begin
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        chk(got, "R8 result arrives", 32'(got), 32'd1);
        chk(gf == ef, (ef == 2'b10) ? "R4/R5 fault code" : (ef == 2'b01) ? "R3 fault code" : "R1 fault code",
            32'(gf), 32'(ef));
        chk(gp == ep, (ef == 2'b00) ? "R1 physical address" : "R7 zero address on fault", 32'(gp), 32'(ep));
        chk(reads == ((ef == 2'b00) ? 1 : 0), "R2/R3/R4 read count", 32'(reads), (ef == 2'b00) ? 32'd1 : 32'd0);
        if (ef == 2'b00) chk(ma == ea, "R2 entry address", 32'(ma), 32'(ea));
        @(negedge clk);
        chk(req_ready && !rsp_valid, "R7 ready after result", {30'd0, req_ready, rsp_valid}, 32'd2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int s = 0; s < NSEG; s++) begin
            tb_base[s]   = 24'($urandom);
            tb_limit[s]  = 9'($urandom_range(0, 256));
            tb_rights[s] = 2'($urandom);
        end
        tb_base[0] = 24'h002000; tb_limit[0] = 9'h014; tb_rights[0] = 2'b01;
        tb_base[1] = 24'h000000; tb_limit[1] = 9'h000; tb_rights[1] = 2'b00;
        tb_base[2] = 24'h001000; tb_limit[2] = 9'h00d; tb_rights[2] = 2'b11;
        tb_base[3] = 24'hfffff0; tb_limit[3] = 9'h100; tb_rights[3] = 2'b11;
        pack_table();

        repeat (3) @(negedge clk);
        // R9 reset state while held in reset
        chk(req_ready == 1'b1, "R9 ready in reset", 32'(req_ready), 32'd1);
        chk(mem_req == 1'b0, "R9 no read in reset", 32'(mem_req), 32'd0);
        chk(rsp_valid == 1'b0, "R9 no result in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready after reset", 32'(req_ready), 32'd1);

        // R1 R2 R10 directed vector: segment 0 page 0x11 -> 0x01f424
        xlat(24'h011424, 1'b0, 2, 1'b0);
        // R3 page past limit of segment 2
        xlat(24'h210014, 1'b0, 1, 1'b0);
        // R4 segment with no rights
        xlat(24'h104c84, 1'b0, 1, 1'b0);
        // R4 write to read-only segment
        xlat(24'h002abc, 1'b1, 1, 1'b0);
        // R5 write to read-only segment with page past limit too
        xlat(24'h020000, 1'b1, 1, 1'b0);
        // R3 boundaries: page limit-1 passes, page == limit faults
        xlat(24'h20c7ff, 1'b1, 3, 1'b0);
        xlat(24'h20d000, 1'b0, 3, 1'b0);
        // R3 full 256-page segment, with address wrap in R2
        xlat(24'h3ff123, 1'b1, 1, 1'b0);
        // R6 request held with other address while busy
        xlat(24'h013001, 1'b0, 4, 1'b1);
        // R8 long memory latency
        xlat(24'h205555, 1'b0, 9, 1'b0);

        // random mix over all segments (R10 descriptor selection)
        for (int n = 0; n < 300; n++) begin
            xlat(24'($urandom), 1'($urandom), int'($urandom_range(1, 5)), 1'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule